// File: doc/BRIEF.md
# Parity-Checked AES Forward Substitution Unit

This block replaces each byte of a stream with its AES forward S-box value and checks every substitution for faults using even parity (parity bit = XOR of the eight data bits). The substitution itself is computed by combinational logic: the byte is mapped into a tower field GF((2^4)^2), inverted there with nibble multiply, square and constant-multiply units, mapped back, and passed through the affine transform. No stored value table is used for the substitution.

Two independent parity predictions guard the datapath. A table indexed by the incoming byte predicts the parity of the result. A second table, indexed by the registered result, predicts the parity of the byte that produced it. That prediction is compared with the parity computed from the incoming byte. Predictions made at input time wait in small parity queues until the registered result they belong to is on the output. Any disagreement raises an error flag alongside that byte, and a sticky flag records it until it is cleared. The unit only detects faults; it does not correct them. A test input can invert one chosen bit of the substituted byte, so that the detection path can be exercised.

Bytes enter and leave through valid/ready handshakes with a single output register. The intended fault model is a single stuck-at fault inside the substitution logic.

Top module: `sbox_parity_guard`

## Requirements
- R1: For every input byte x, the byte delivered on `out_byte` equals the AES forward S-box of x (for example 0x00→0x63, 0x01→0x7C, 0x53→0xED) when no fault is injected.
- R2: A byte accepted while the output register is empty or being drained appears with `out_valid` high on the next cycle, and `in_ready` is high whenever `out_valid` is low.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_err` stay unchanged. Bytes leave in the order they were accepted, each exactly once.
- R4: `out_err` is low for every fault-free substitution.
- R5: When `inj_en` is high in the cycle a byte is accepted, bit `inj_sel` of that byte's result (bit 0 = LSB) is inverted, and `out_err` is high while that byte is presented.
- R6: `out_err` is low whenever `out_valid` is low.
- R7: `err_flag` is set on the cycle after any output handshake with `out_err` high. It holds until a cycle with `err_clr` high and no erroneous handshake, which clears it on the following edge. A set takes priority over a clear in the same cycle.
- R8: Synchronous active-high `rst` clears `out_valid`, `out_err` and `err_flag` and empties both parity queues, so predictions left over from before the reset never pair with later bytes.
- R9: `inj_en` has no effect in cycles where no byte is accepted. A later fault-free byte is delivered correctly and without error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte is offered |
| in_byte | input | 8 | Byte to substitute |
| in_ready | output | 1 | Unit can accept a byte this cycle |
| inj_en | input | 1 | Test: invert one result bit of the byte accepted this cycle |
| inj_sel | input | 3 | Test: index of the bit to invert |
| out_valid | output | 1 | Substituted byte is presented |
| out_byte | output | 8 | Substituted byte |
| out_err | output | 1 | Parity check failed for the presented byte |
| out_ready | input | 1 | Consumer takes the presented byte |
| err_clr | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky record of any delivered erroneous byte |

## Verification
All 256 byte values are sent in ascending order, followed by a random stream under random output stalls. This separates a wrong field mapping or affine constant from a handshake fault that drops, repeats or reorders bytes. The eight single-bit inversions are then applied to all-zero, all-one and random bytes. This shows that each result bit position reaches the parity comparison, and a wrong flip mask appears as a byte mismatch rather than as a missing error. Injection pulses without a transfer, and a reset taken while a byte is stalled on the output, separate a correctly aligned prediction queue from one that lets a stale prediction pair with the next byte.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned NIB_W    = 4;
   localparam int unsigned SEL_W    = $clog2(BYTE_W);
   localparam logic [7:0]  POLY8_LO = 8'h1B;   // x^8 + x^4 + x^3 + x + 1
   localparam logic [3:0]  POLY4_LO = 4'h3;    // x^4 + x + 1
   localparam logic [3:0]  LAMBDA   = 4'hC;    // tower constant: y^2 + y + LAMBDA
   localparam logic [7:0]  AFF_ADD  = 8'h63;
   localparam logic [7:0]  INV_ADD  = 8'h05;

   typedef logic [BYTE_W-1:0] byte_t;
   typedef logic [NIB_W-1:0]  nib_t;

   function automatic byte_t rotl8(byte_t b, int unsigned n);
      return byte_t'((b << n) | (b >> (BYTE_W - n)));
   endfunction

   function automatic byte_t gf8_mul(byte_t a, byte_t b);
      byte_t acc = '0;
      byte_t x   = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc ^= x;
         x = x[7] ? ({x[6:0], 1'b0} ^ POLY8_LO) : {x[6:0], 1'b0};
      end
      return acc;
   endfunction

   // a^254 = a^2 * a^4 * ... * a^128 ; zero maps to zero
   function automatic byte_t gf8_inv(byte_t a);
      byte_t sq  = a;
      byte_t acc = 8'h01;
      for (int i = 1; i < 8; i++) begin
         sq  = gf8_mul(sq, sq);
         acc = gf8_mul(acc, sq);
      end
      return acc;
   endfunction

   function automatic byte_t affine_fwd(byte_t b);
      return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ AFF_ADD;
   endfunction

   function automatic byte_t affine_rev(byte_t s);
      return rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ INV_ADD;
   endfunction

   function automatic byte_t ref_sbox(byte_t x);
      return affine_fwd(gf8_inv(x));
   endfunction

   function automatic byte_t ref_inv_sbox(byte_t s);
      return gf8_inv(affine_rev(s));
   endfunction

   // ---------------- GF(2^4) units ----------------
   function automatic nib_t gf4_mul(nib_t a, nib_t b);
      nib_t acc = '0;
      nib_t x   = a;
      for (int i = 0; i < 4; i++) begin
         if (b[i]) acc ^= x;
         x = x[3] ? ({x[2:0], 1'b0} ^ POLY4_LO) : {x[2:0], 1'b0};
      end
      return acc;
   endfunction

   function automatic nib_t gf4_sq(nib_t a);
      return gf4_mul(a, a);
   endfunction

   function automatic nib_t gf4_mul_lambda(nib_t a);
      return gf4_mul(a, LAMBDA);
   endfunction

   // a^14 = a^2 * a^4 * a^8
   function automatic nib_t gf4_inv(nib_t a);
      nib_t s2 = gf4_sq(a);
      nib_t s4 = gf4_sq(s2);
      nib_t s8 = gf4_sq(s4);
      return gf4_mul(gf4_mul(s2, s4), s8);
   endfunction

   // ---------------- basis change, derived at elaboration ----------------
   function automatic byte_t find_nib_root();
      byte_t r = 8'h02;
      for (int v = 255; v >= 2; v--) begin
         byte_t c  = byte_t'(v);
         byte_t c2 = gf8_mul(c, c);
         if ((gf8_mul(c2, c2) ^ c ^ 8'h01) == 8'h00) r = c;
      end
      return r;
   endfunction

   function automatic byte_t embed_nib(nib_t n, byte_t w);
      byte_t acc = '0;
      byte_t p   = 8'h01;
      for (int i = 0; i < 4; i++) begin
         if (n[i]) acc ^= p;
         p = gf8_mul(p, w);
      end
      return acc;
   endfunction

   function automatic byte_t find_tower_root(byte_t w);
      byte_t lam = embed_nib(LAMBDA, w);
      byte_t r   = 8'h02;
      for (int v = 255; v >= 2; v--) begin
         byte_t c = byte_t'(v);
         if ((gf8_mul(c, c) ^ c ^ lam) == 8'h00) r = c;
      end
      return r;
   endfunction

   // column j (bits 8j+7..8j) is the image of basis bit j
   function automatic logic [63:0] tower_to_std_map();
      logic [63:0] m = '0;
      byte_t w = find_nib_root();
      byte_t y = find_tower_root(w);
      for (int k = 0; k < 4; k++) begin
         m[8*k +: 8]     = embed_nib(nib_t'(1 << k), w);
         m[8*(k+4) +: 8] = gf8_mul(embed_nib(nib_t'(1 << k), w), y);
      end
      return m;
   endfunction

   function automatic byte_t apply_map(logic [63:0] m, byte_t v);
      byte_t acc = '0;
      for (int j = 0; j < 8; j++)
         if (v[j]) acc ^= m[8*j +: 8];
      return acc;
   endfunction

   function automatic logic [63:0] std_to_tower_map(logic [63:0] fwd);
      logic [63:0] m = '0;
      for (int j = 0; j < 8; j++)
         for (int q = 0; q < 256; q++)
            if (apply_map(fwd, byte_t'(q)) == byte_t'(1 << j)) m[8*j +: 8] = byte_t'(q);
      return m;
   endfunction

   localparam logic [63:0] TOWER_TO_STD = tower_to_std_map();
   localparam logic [63:0] STD_TO_TOWER = std_to_tower_map(TOWER_TO_STD);

endpackage

// File: rtl/sbp_sbox_dp.sv
module sbp_sbox_dp
   import sbp_pkg::*;
(
   input  byte_t din,
   output byte_t dout
);

   byte_t tw_in;
   byte_t tw_out;
   nib_t  hi, lo;
   nib_t  norm;
   nib_t  norm_inv;
   nib_t  hi_inv, lo_inv;

   // map into GF((2^4)^2): element = hi*Y + lo, Y^2 = Y + LAMBDA
   assign tw_in = apply_map(STD_TO_TOWER, din);
   assign hi    = tw_in[7:4];
   assign lo    = tw_in[3:0];

   // (hi*Y + lo)^-1 = hi*t*Y + (hi^lo)*t, t = 1/(LAMBDA*hi^2 + hi*lo + lo^2)
   assign norm     = gf4_mul_lambda(gf4_sq(hi)) ^ gf4_mul(hi, lo) ^ gf4_sq(lo);
   assign norm_inv = gf4_inv(norm);
   assign hi_inv   = gf4_mul(hi, norm_inv);
   assign lo_inv   = gf4_mul(hi ^ lo, norm_inv);

   assign tw_out = apply_map(TOWER_TO_STD, {hi_inv, lo_inv});
   assign dout   = affine_fwd(tw_out);

endmodule

// File: rtl/sbp_parity_rom.sv
module sbp_parity_rom
   import sbp_pkg::*;
#(
   // 0: indexed by the input byte, gives parity of its substitute
   // 1: indexed by a substitute, gives parity of the byte it came from
   parameter bit INDEX_BY_RESULT = 1'b0
)(
   input  byte_t addr,
   output logic  pred
);

   localparam int unsigned ENTRIES = 1 << BYTE_W;

   logic [ENTRIES-1:0] par_col;

   generate
      if (INDEX_BY_RESULT) begin : g_src_side
         for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
            assign par_col[i] = ^ref_inv_sbox(byte_t'(i));
         end
      end else begin : g_dst_side
         for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
            assign par_col[i] = ^ref_sbox(byte_t'(i));
         end
      end
   endgenerate

   assign pred = par_col[addr];

endmodule

// File: rtl/sbp_par_fifo.sv
module sbp_par_fifo #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned WIDTH = 1
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);

   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("sbp_par_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         end
         if (do_pop)
            rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/sbox_parity_guard.sv
module sbox_parity_guard
   import sbp_pkg::*;
#(
   parameter int unsigned PAR_FIFO_DEPTH = 2
)(
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   output logic             in_ready,
   input  logic             inj_en,
   input  logic [SEL_W-1:0] inj_sel,
   output logic             out_valid,
   output logic [7:0]       out_byte,
   output logic             out_err,
   input  logic             out_ready,
   input  logic             err_clr,
   output logic             err_flag
);

   localparam int unsigned OUT_LATENCY = 1;
   localparam int unsigned N_LANES     = 2;   // lane 0: result parity, lane 1: source parity

   generate
      if (PAR_FIFO_DEPTH < OUT_LATENCY + 1) begin : g_bad_depth
         $error("sbox_parity_guard: PAR_FIFO_DEPTH must cover latency plus one");
      end
   endgenerate

   byte_t              sub_raw, sub_inj, flip_mask;
   byte_t              res_q;
   logic               vld_q, sticky_q;
   logic               accept, release_o;
   logic               pred_dst_par, pred_src_par;
   logic               mismatch;
   logic [N_LANES-1:0] lane_push, lane_head, lane_empty, lane_full;

   // ---------------- substitution datapath ----------------
   sbp_sbox_dp u_dp (
      .din  (in_byte),
      .dout (sub_raw)
   );

   always_comb begin
      flip_mask = '0;
      if (inj_en) flip_mask[inj_sel] = 1'b1;
   end
   assign sub_inj = sub_raw ^ flip_mask;

   // ---------------- handshake and output register ----------------
   assign in_ready  = (!vld_q || out_ready) && !(|lane_full);
   assign accept    = in_valid && in_ready;
   assign release_o = vld_q && out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_q <= 1'b0;
         res_q <= '0;
      end else if (accept) begin
         vld_q <= 1'b1;
         res_q <= sub_inj;
      end else if (release_o) begin
         vld_q <= 1'b0;
      end
   end

   // ---------------- parity prediction ----------------
   sbp_parity_rom #(.INDEX_BY_RESULT(1'b0)) u_rom_dst (
      .addr (in_byte),
      .pred (pred_dst_par)
   );

   sbp_parity_rom #(.INDEX_BY_RESULT(1'b1)) u_rom_src (
      .addr (res_q),
      .pred (pred_src_par)
   );

   assign lane_push[0] = pred_dst_par;
   assign lane_push[1] = ^in_byte;

   generate
      for (genvar l = 0; l < N_LANES; l++) begin : g_lane
         sbp_par_fifo #(.DEPTH(PAR_FIFO_DEPTH), .WIDTH(1)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (accept),
            .din   (lane_push[l]),
            .pop   (release_o),
            .dout  (lane_head[l]),
            .empty (lane_empty[l]),
            .full  (lane_full[l])
         );
      end
   endgenerate

   // ---------------- comparators ----------------
   assign mismatch  = ((^res_q) != lane_head[0]) || (pred_src_par != lane_head[1]);
   assign out_err   = vld_q && !(|lane_empty) && mismatch;
   assign out_valid = vld_q;
   assign out_byte  = res_q;

   always_ff @(posedge clk) begin
      if (rst)
         sticky_q <= 1'b0;
      else if (release_o && out_err)
         sticky_q <= 1'b1;
      else if (err_clr)
         sticky_q <= 1'b0;
   end
   assign err_flag = sticky_q;

endmodule

// File: rtl/sbp_guard_chk.sv
module sbp_guard_chk (
   input logic       clk,
   input logic       rst,
   input logic       in_valid,
   input logic       in_ready,
   input logic       out_valid,
   input logic [7:0] out_byte,
   input logic       out_err,
   input logic       out_ready,
   input logic       err_clr,
   input logic       err_flag
);

   AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> !out_err);  // R6

   AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_err));  // R3

   AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (rst)
      in_valid && in_ready |=> out_valid);  // R2

   AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);  // R2

   AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_ready && out_err |=> err_flag);  // R7

   AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
      err_clr && !(out_valid && out_ready && out_err) |=> !err_flag);  // R7

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      err_flag && !err_clr |=> err_flag);  // R7

endmodule

bind sbox_parity_guard sbp_guard_chk u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_byte  (out_byte),
   .out_err   (out_err),
   .out_ready (out_ready),
   .err_clr   (err_clr),
   .err_flag  (err_flag)
);

// File: tb/sbox_parity_guard_tb.sv
module sbox_parity_guard_tb;

   localparam int CLK_PERIOD   = 10;
   localparam int WATCHDOG_CYC = 100000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_byte = '0;
   logic       in_ready;
   logic       inj_en = 1'b0;
   logic [2:0] inj_sel = '0;
   logic       out_valid;
   logic [7:0] out_byte;
   logic       out_err;
   logic       out_ready = 1'b1;
   logic       err_clr = 1'b0;
   logic       err_flag;

   int n_chk  = 0;
   int n_fail = 0;
   int ready_mode = 0;      // 0 always ready, 1 random, 2 held low
   logic [8:0] exp_q[$];    // {expected error, expected byte}

   always #(CLK_PERIOD/2) clk = ~clk;

   sbox_parity_guard u_dut (
      .clk (clk), .rst (rst),
      .in_valid (in_valid), .in_byte (in_byte), .in_ready (in_ready),
      .inj_en (inj_en), .inj_sel (inj_sel),
      .out_valid (out_valid), .out_byte (out_byte), .out_err (out_err),
      .out_ready (out_ready), .err_clr (err_clr), .err_flag (err_flag)
   );

   // ---------------- independent reference ----------------
   function automatic logic [7:0] tb_mul(logic [7:0] a, logic [7:0] b);
      logic [7:0] r = '0;
      logic [7:0] x = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) r ^= x;
         x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1B) : {x[6:0], 1'b0};
      end
      return r;
   endfunction

   function automatic logic [7:0] tb_sbox(logic [7:0] v);
      logic [7:0] inv = '0;
      logic [7:0] s;
      for (int y = 1; y < 256; y++)
         if (tb_mul(v, 8'(y)) == 8'h01) inv = 8'(y);
      s = inv;
      for (int k = 1; k <= 4; k++)
         s ^= 8'((inv << k) | (inv >> (8 - k)));
      return s ^ 8'h63;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // ---------------- monitor / scoreboard ----------------
   bit         prev_stall = 0;
   logic [7:0] prev_byte  = '0;
   logic       prev_err   = 1'b0;

   always @(negedge clk) begin
      if (rst) begin
         prev_stall = 0;
         out_ready  = 1'b1;
      end else begin
         case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = 1'($urandom_range(0, 1));
            default: out_ready = 1'b0;
         endcase
         #1;
         if (!out_valid)
            check(out_err == 1'b0, "R6", "error without valid", 32'(out_err), 0);
         if (prev_stall)
            check(out_valid && out_byte == prev_byte && out_err == prev_err, "R3",
                  "stalled output changed", {23'd0, out_valid, out_err, out_byte},
                  {23'd0, 1'b1, prev_err, prev_byte});
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R3", "unexpected output byte", 32'(out_byte), 0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               check(out_byte == e[7:0], e[8] ? "R5" : "R1", "substituted byte",
                     32'(out_byte), 32'(e[7:0]));
               check(out_err == e[8], e[8] ? "R5" : "R4", "error flag with byte",
                     32'(out_err), 32'(e[8]));
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_byte  = out_byte;
         prev_err   = out_err;
      end
   end

   // ---------------- driver ----------------
   task automatic send(input logic [7:0] b, input bit inj, input logic [2:0] k);
      logic [7:0] e;
      in_valid = 1'b1;
      in_byte  = b;
      inj_en   = inj;
      inj_sel  = k;
      #2;
      while (!in_ready) begin
         @(negedge clk);
         #2;
      end
      e = tb_sbox(b);
      if (inj) e[k] = ~e[k];
      exp_q.push_back({inj, e});
      @(negedge clk);
      in_valid = 1'b0;
      inj_en   = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      check(1'b0, "R2", "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      #2;
      check(!out_valid && !out_err && !err_flag && in_ready, "R8", "state after reset",
            {29'd0, out_valid, out_err, err_flag}, 0);

      // known values and one-cycle latency
      ready_mode = 0;
      send(8'h53, 1'b0, 3'd0);
      #2;
      check(out_valid && out_byte == 8'hED, "R2", "byte one cycle after accept",
            {23'd0, out_valid, out_byte}, {23'd0, 1'b1, 8'hED});
      check(tb_sbox(8'h00) == 8'h63 && tb_sbox(8'h01) == 8'h7C, "R1", "reference spot values",
            {16'd0, tb_sbox(8'h00), tb_sbox(8'h01)}, 32'h637C);
      @(negedge clk);
      send(8'h00, 1'b0, 3'd0);
      send(8'h01, 1'b0, 3'd0);
      drain();

      // full byte sweep and random stream under random stalls
      ready_mode = 1;
      for (int v = 0; v < 256; v++) send(8'(v), 1'b0, 3'd0);
      for (int n = 0; n < 200; n++) send(8'($urandom_range(0, 255)), 1'b0, 3'd0);
      drain();
      check(err_flag == 1'b0, "R4", "sticky flag after clean stream", 32'(err_flag), 0);

      // single-bit fault injection on each result bit
      for (int k = 0; k < 8; k++) begin
         send(8'h00, 1'b1, 3'(k));
         send(8'hFF, 1'b1, 3'(k));
         send(8'($urandom_range(0, 255)), 1'b1, 3'(k));
         send(8'($urandom_range(0, 255)), 1'b0, 3'd0);
      end
      drain();
      check(err_flag == 1'b1, "R7", "sticky flag after faults", 32'(err_flag), 1);
      ready_mode = 0;
      repeat (3) @(negedge clk);
      #2;
      check(err_flag == 1'b1, "R7", "sticky flag holds", 32'(err_flag), 1);
      @(negedge clk);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      #2;
      check(err_flag == 1'b0, "R7", "sticky flag cleared", 32'(err_flag), 0);

      // injection with no transfer has no effect
      @(negedge clk);
      inj_en  = 1'b1;
      inj_sel = 3'd3;
      repeat (4) @(negedge clk);
      inj_en = 1'b0;
      for (int n = 0; n < 6; n++) send(8'($urandom_range(0, 255)), 1'b0, 3'd0);
      drain();
      check(err_flag == 1'b0, "R9", "idle injection left no error", 32'(err_flag), 0);

      // reset while a byte is stalled on the output
      ready_mode = 2;
      @(negedge clk);
      send(8'hA5, 1'b0, 3'd0);
      repeat (3) @(negedge clk);
      #2;
      check(out_valid == 1'b1 && in_ready == 1'b0, "R3", "stalled output blocks input",
            {30'd0, out_valid, in_ready}, 32'h2);
      rst = 1'b1;
      exp_q.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      ready_mode = 0;
      #2;
      check(!out_valid && !err_flag && in_ready, "R8", "state after mid-stream reset",
            {29'd0, out_valid, err_flag, in_ready}, 1);
      @(negedge clk);
      for (int n = 0; n < 5; n++) send(8'(8'h10 + n), 1'b0, 3'd0);
      drain();
      check(err_flag == 1'b0, "R8", "no stale prediction after reset", 32'(err_flag), 0);

      summary();
      $finish;
   end

endmodule